// File: doc/BRIEF.md
# Stop-Mode Wake-Up Countdown Timer

This block is a 16-bit countdown timer. It counts edges of a slow, always-running ring clock of about 8 kHz. Its counting logic sits entirely in that slow domain, so it keeps running while the rest of the chip is in stop mode. Software first loads the interval register. It then sets the run bit in the control register. The slow domain loads the interval and counts it down to zero. When the count reaches zero, an event crosses back to the system domain and sets a sticky done flag. The total delay is the interval times the ring-clock period, up to 65535 periods.

The done flag drives the interrupt line only while the global interrupt enable is high. The wake request is the interrupt qualified by the stop-mode indicator. The chip can therefore leave stop mode only when the interrupt really fires. The run bit goes to the slow domain through two flops, and so does the interval. The interval is held constant while the timer runs, which makes that crossing safe. The zero event returns as a toggle through two flops.

Top module: `wake_countdown`

## Requirements
- R1: After reset, the interval reads 0, the control register reads 0, and irq and wake are low.
- R2: A write to address 0 sets the interval. A read of address 0 returns it. Address 1 is control: bit 0 is run and bit 1 is the done flag, and all other bits read as 0.
- R3: Setting run with a nonzero interval N sets the done flag after N slow-clock periods plus the synchronizer delay. The flag is seen at the ports between N+1 and N+5 slow-clock rising edges after the write.
- R4: The done flag stays set until software writes control with bit 1 at 1. Hardware clears run in the same cycle that it sets the flag.
- R5: irq is high exactly while the done flag and gie are both high.
- R6: wake is high only while irq and stop_mode are both high.
- R7: The countdown keeps going and completes while stop_mode is high.
- R8: Run set with an interval of 0 starts no countdown and sets no flag. Run stays set.
- R9: Writes to the interval while run is 1 are ignored.
- R10: Clearing run during a countdown aborts it, and the done flag is never set.
- R11: Setting run again after a completed countdown starts a new countdown from the current interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rclk | input | 1 | Slow ring clock, always running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 interval, 1 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read address: 0 interval, 1 control |
| rd_data | output | 16 | Read data for rd_addr |
| stop_mode | input | 1 | High while the system is in stop mode |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Stop-mode exit request |

## Verification
The countdown is run with intervals of 5, 1 and 300. Each completion time is compared against a window measured in slow-clock edges, which separates a correct count from off-by-some or non-decrementing counters. Other runs cover the side cases: one in stop mode, one with gie low, one with interval 0, one aborted mid-count, and one with an interval rewrite during counting. These separate the gating of irq and wake, the zero-interval case, abort handling and the interval lock.

// File: rtl/wake_countdown.sv
module wake_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rclk,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         stop_mode,
  input  logic         gie,
  output logic         irq,
  output logic         wake
);

  logic [W-1:0] ival;
  logic         en, flag;
  logic         dn_s1, dn_s2, dn_q;
  logic         done_evt;

  logic         en_s1, en_s2, en_q;
  logic [W-1:0] iv_s1, iv_s2;
  logic [W-1:0] cnt;
  logic         active;
  logic         dn_t;

  assign done_evt = dn_s2 ^ dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival  <= '0;
      en    <= 1'b0;
      flag  <= 1'b0;
      dn_s1 <= 1'b0;
      dn_s2 <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      dn_s1 <= dn_t;
      dn_s2 <= dn_s1;
      dn_q  <= dn_s2;
      if (wr_en && !wr_addr && !en)
        ival <= wr_data;
      if (done_evt) begin
        flag <= 1'b1;
        en   <= 1'b0;
      end else if (wr_en && wr_addr) begin
        en <= wr_data[0];
        if (wr_data[1]) flag <= 1'b0;
      end
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1  <= 1'b0;
      en_s2  <= 1'b0;
      en_q   <= 1'b0;
      iv_s1  <= '0;
      iv_s2  <= '0;
      cnt    <= '0;
      active <= 1'b0;
      dn_t   <= 1'b0;
    end else begin
      en_s1 <= en;
      en_s2 <= en_s1;
      en_q  <= en_s2;
      iv_s1 <= ival;
      iv_s2 <= iv_s1;
      if (!en_s2) begin
        active <= 1'b0;
      end else if (!en_q) begin
        cnt    <= iv_s2;
        active <= (iv_s2 != '0);
      end else if (active) begin
        cnt <= cnt - 1'b1;
        if (cnt == W'(1)) begin
          active <= 1'b0;
          dn_t   <= ~dn_t;
        end
      end
    end
  end

  assign rd_data = rd_addr ? {{(W-2){1'b0}}, flag, en} : ival;
  assign irq     = flag & gie;
  assign wake    = irq & stop_mode;

endmodule

// File: rtl/wake_countdown_chk.sv
module wake_countdown_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rclk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] ival,
  input logic         en,
  input logic         flag,
  input logic         en_s2,
  input logic         en_q,
  input logic [W-1:0] iv_s2,
  input logic [W-1:0] cnt,
  input logic         active
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && wr_addr && wr_data[1]) |=> flag); // R4

  AST_RUN_DROPS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !en); // R4

  AST_IVAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(ival)); // R9

  AST_COUNT_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
    active && cnt > W'(1) && en_s2 && en_q |=> active && cnt == $past(cnt) - W'(1)); // R3

  AST_ZERO_NO_START: assert property (@(posedge rclk) disable iff (!rst_n)
    en_s2 && !en_q && iv_s2 == '0 |=> !active); // R8

  AST_ABORT_STOPS: assert property (@(posedge rclk) disable iff (!rst_n)
    !en_s2 |=> !active); // R10

endmodule

bind wake_countdown wake_countdown_chk #(.W(W)) u_chk (
  .clk(clk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ival(ival), .en(en), .flag(flag), .en_s2(en_s2),
  .en_q(en_q), .iv_s2(iv_s2), .cnt(cnt), .active(active)
);

// File: tb/sim_wake_countdown.sv
module sim_wake_countdown;
  logic        clk = 0, rclk = 0, rst_n = 0;
  logic        wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        stop_mode = 0, gie = 0;
  logic        irq, wake;

  int errs = 0, checks = 0;
  int rclk_cnt = 0;
  int exp_q[$];
  int start_q[$];
  bit mon_off = 0;
  bit prev_irq = 0;
  bit done = 0;

  always #5 clk = ~clk;
  initial begin #3; forever #25 rclk = ~rclk; end
  always @(posedge rclk) rclk_cnt++;

  wake_countdown u0 (
    .clk(clk), .rst_n(rst_n), .rclk(rclk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stop_mode(stop_mode), .gie(gie), .irq(irq), .wake(wake)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(bit a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic start(int n, bit expect_done);
    @(negedge clk);
    wr_en = 1; wr_addr = 1; wr_data = 16'h0001;
    if (expect_done) begin
      exp_q.push_back(n);
      start_q.push_back(rclk_cnt);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_done(int n, string req);
    int t = 0;
    while (exp_q.size() != 0 && t < n * 5 + 200) begin
      @(negedge clk); t++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete(); start_q.delete();
  endtask

  // monitor: pops expected completions as irq rises
  always @(negedge clk) begin
    if (!rst_n) prev_irq = 0;
    else begin
      if (irq && !prev_irq && !mon_off) begin
        if (exp_q.size() == 0) check(0, "R10 unexpected irq", 1, 0);
        else begin
          int n, st, el;
          n = exp_q.pop_front();
          st = start_q.pop_front();
          el = rclk_cnt - st;
          check(el >= n + 1 && el <= n + 5, "R3 completion edges", el, n + 3);
        end
      end
      prev_irq = irq;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(0, v); check(v == 0, "R1 interval", v, 0);
    rd(1, v); check(v == 0, "R1 control", v, 0);
    check(irq == 0 && wake == 0, "R1 irq/wake", {irq, wake}, 0);

    wr(0, 16'h1234); rd(0, v); check(v == 'h1234, "R2 interval readback", v, 'h1234);
    wr(0, 5);        rd(0, v); check(v == 5, "R2 interval readback", v, 5);

    gie = 1;
    start(5, 1); wait_done(5, "R3 run 5");
    rd(1, v); check(v == 2, "R4 flag set run cleared", v, 2);
    repeat (40) @(negedge clk);
    rd(1, v); check(v == 2, "R4 flag sticky", v, 2);
    wr(1, 2); rd(1, v); check(v == 0, "R4 flag cleared", v, 0);
    check(irq == 0, "R5 irq low after clear", irq, 0);

    wr(0, 1); start(1, 1); wait_done(1, "R11 restart run 1");
    wr(1, 2);

    wr(0, 300); start(300, 1);
    wr(0, 7); rd(0, v); check(v == 300, "R9 interval locked", v, 300);
    wait_done(300, "R3 run 300");
    wr(1, 2);

    stop_mode = 1;
    wr(0, 4); start(4, 1);
    repeat (3) @(negedge clk);
    check(wake == 0, "R6 no wake before done", wake, 0);
    wait_done(4, "R7 done in stop mode");
    @(negedge clk); check(wake == 1, "R6 wake in stop", wake, 1);
    stop_mode = 0;
    @(negedge clk); check(wake == 0, "R6 wake needs stop", wake, 0);
    wr(1, 2);

    mon_off = 1; gie = 0; stop_mode = 1;
    wr(0, 3); start(3, 0);
    repeat (80) @(negedge clk);
    rd(1, v); check(v == 2, "R5 flag set with gie low", v, 2);
    check(irq == 0, "R5 irq masked", irq, 0);
    check(wake == 0, "R6 no wake without gie", wake, 0);
    gie = 1; #1;
    check(irq == 1, "R5 irq with gie", irq, 1);
    stop_mode = 0;
    wr(1, 2);
    @(negedge clk); mon_off = 0;

    wr(0, 0); start(0, 0);
    repeat (100) @(negedge clk);
    rd(1, v); check(v == 1, "R8 zero interval no flag", v, 1);
    check(irq == 0, "R8 no irq", irq, 0);
    wr(1, 0);

    wr(0, 40); start(40, 0);
    repeat (50) @(negedge clk);
    wr(1, 0);
    repeat (300) @(negedge clk);
    rd(1, v); check(v == 0, "R10 abort no flag", v, 0);
    check(irq == 0, "R10 no irq", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule